// File: doc/BRIEF.md
# Timed-Event Record Fetch Engine

This engine walks a byte-packed list of timed events held in memory. It turns each event into one write command on a downstream timed-output command port. A controller loads a start address and then pulses a start strobe. The engine then fetches 64-bit words over an AXI read address/data channel pair, using fixed-length incrementing bursts. It stages the words in a small buffer and walks the byte stream one byte per cycle. Each record it parses becomes a command that carries a channel, a 64-bit timestamp, an 8-bit sub-address and up to 64 data bytes.

A record begins with a length byte. This byte counts every byte of the record, the length byte included. A zero length byte ends the list. When the end is reached, the engine drops any words it has already fetched and waits for every outstanding read beat to return. It then drops its busy flag, so a following run from another address sees none of the earlier data. The downstream side paces the engine with a busy input and reports two kinds of failure through pulses. The engine keeps these failures as sticky flags until the controller clears them.

Top module: `evrec_dma`

## Requirements
- R1: After `ctl_start` is pulsed while idle, `stat_enable` reads 1 from the next cycle. It returns to 0 only after the terminating zero length byte has been consumed and every requested read beat has arrived. A `ctl_start` pulse or a base write during a run has no effect on that run.
- R2: Every read request is an incrementing burst: `m_ar_burst`=2'b01, `m_ar_size`=3'b011, `m_ar_len`=BURST-1. The first request goes to the loaded base with its low 3 bits cleared, and each later request is BURST*8 bytes above the one before. A request held without `m_ar_ready` keeps its address.
- R3: Within each 64-bit read word, the earliest byte of the stream sits in bits 63:56 and the latest in bits 7:0. Records may begin and end at any byte position and may span words.
- R4: A record with length byte L (14 to 77) is laid out as follows: the length byte, then channel (3 bytes), then timestamp (8 bytes), then sub-address (1 byte), then L-13 data bytes. Every multi-byte field is least significant byte first. The data field appears on `ev_data` zero-extended to 512 bits.
- R5: Each record yields exactly one `ev_valid` pulse, one cycle long. Commands appear in the order the records sit in memory, and there are no others.
- R6: `ev_valid` is asserted only if `ev_busy` was 0 in the previous cycle. When busy is held for H cycles after each command, consecutive commands are at least H+2 cycles apart.
- R7: A zero length byte stops parsing. Bytes that follow it, including nonzero filler, produce no command. Two consecutive runs from different bases each yield only their own records.
- R8: `stat_err` bit 0 latches an `ev_err_underflow` pulse and bit 1 latches an `ev_err_unreach` pulse. Each bit holds until a 1 is written to the matching bit of `ctl_err_clr`. A new pulse in the same cycle as a clear wins. No bit sets without its pulse.
- R9: After reset, `stat_enable`, `ev_valid`, `m_ar_valid` and `stat_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_base_wr | input | 1 | Load strobe for the base address |
| ctl_base_data | input | AW | Base address value |
| ctl_start | input | 1 | Start strobe, honoured only while idle |
| ctl_err_clr | input | 2 | Write-1-to-clear mask for the error flags |
| stat_enable | output | 1 | 1 while a run is in progress |
| stat_err | output | 2 | Sticky flags: bit 0 underflow, bit 1 unreachable |
| m_ar_valid | output | 1 | Read request valid |
| m_ar_ready | input | 1 | Read request accepted |
| m_ar_addr | output | AW | Read burst byte address |
| m_ar_len | output | 8 | Burst beats minus one |
| m_ar_size | output | 3 | Beat size code (8 bytes) |
| m_ar_burst | output | 2 | Burst type (incrementing) |
| m_r_valid | input | 1 | Read data valid |
| m_r_ready | output | 1 | Read data accepted |
| m_r_data | input | 64 | Read data word |
| ev_valid | output | 1 | Command strobe |
| ev_chan | output | 24 | Command channel |
| ev_time | output | 64 | Command timestamp |
| ev_addr | output | 8 | Command sub-address |
| ev_data | output | 512 | Command data, zero-extended |
| ev_busy | input | 1 | Downstream busy status |
| ev_err_underflow | input | 1 | Downstream underflow pulse |
| ev_err_unreach | input | 1 | Downstream unreachable pulse |

## Verification
The first list has three records whose lengths leave the later ones straddling word edges. One record carries 20 data bytes, so any byte-lane or order mistake in a field shows up. The list is run with a short busy hold and with a mid-run restart attempt, which separates an engine that ignores the restart from one that jumps to the new base. The second list, at a different base, follows at once. It has data lengths from 1 to 5 bytes and a full 64-byte record, which exposes zero-extension and lane errors at both ends of the data field. It runs under a long busy hold, which shows whether the engine truly waits for busy to clear. Nonzero filler after each terminator shows whether parsing really stops, and a separate error sequence checks that the flags latch, hold and clear on their own.

// File: rtl/evrec_pkg.sv
package evrec_pkg;
  localparam int CHAN_W    = 24;
  localparam int TS_W      = 64;
  localparam int EADDR_W   = 8;
  localparam int EDATA_W   = 512;
  localparam int WORD_W    = 64;
  localparam int MAX_DBYTES = EDATA_W / 8;
  // length byte + channel + timestamp + sub-address
  localparam int HDR_BYTES = 1 + CHAN_W / 8 + TS_W / 8 + EADDR_W / 8;

  typedef struct packed {
    logic [CHAN_W-1:0]  chan;
    logic [TS_W-1:0]    ts;
    logic [EADDR_W-1:0] addr;
    logic [EDATA_W-1:0] data;
  } evcmd_t;

  typedef enum logic [1:0] {PS_IDLE, PS_LEN, PS_BODY, PS_ISSUE} pstate_e;
  typedef enum logic [1:0] {FS_IDLE, FS_RUN, FS_DRAIN} fstate_e;
endpackage

// File: rtl/evrec_wordbuf.sv
module evrec_wordbuf #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
    if (rd_en) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= wp + AW'(1);
      if (rd_en) rp <= rp + AW'(1);
      count <= count + (wr_en ? CW'(1) : CW'(0)) - (rd_en ? CW'(1) : CW'(0));
    end
  end

  assign empty = (count == '0);
endmodule

// File: rtl/evrec_fetch.sv
module evrec_fetch
  import evrec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BURST = 4,
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  localparam int OW   = $clog2(DEPTH + BURST + 1),
  localparam int BURST_BYTES = BURST * (WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic              stop,
  input  logic [CW-1:0]     buf_count,
  output logic              active,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [AW-1:0]     ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [WORD_W-1:0] r_data,
  output logic              push,
  output logic [WORD_W-1:0] push_data
);
  fstate_e       st;
  logic [OW-1:0] outst;
  logic          ar_hs, r_hs, room;

  assign ar_len   = 8'(BURST - 1);
  assign ar_size  = 3'(3);
  assign ar_burst = 2'b01;
  assign r_ready  = 1'b1;
  assign ar_hs    = ar_valid && ar_ready;
  assign r_hs     = r_valid;

  // a burst is requested only when the buffer can take every beat in flight
  assign room = (int'(buf_count) + int'(outst) + BURST) <= DEPTH;

  assign push      = r_hs && (st == FS_RUN) && !stop;
  assign push_data = r_data;
  assign active    = (st != FS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      ar_valid <= 1'b0;
      ar_addr  <= '0;
      outst    <= '0;
    end else begin
      outst <= outst + (ar_hs ? OW'(BURST) : OW'(0)) - (r_hs ? OW'(1) : OW'(0));
      if (ar_hs) begin
        ar_valid <= 1'b0;
        ar_addr  <= ar_addr + AW'(BURST_BYTES);
      end
      unique case (st)
        FS_IDLE: if (start) begin
          st      <= FS_RUN;
          ar_addr <= base & ~AW'(7);
        end
        FS_RUN: begin
          if (stop) st <= FS_DRAIN;
          else if (!ar_valid && room) ar_valid <= 1'b1;
        end
        FS_DRAIN: if (!ar_valid && outst == '0) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evrec_parser.sv
module evrec_parser
  import evrec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              buf_empty,
  output logic              buf_rd,
  input  logic [WORD_W-1:0] buf_data,
  input  logic              dn_busy,
  output logic              cmd_valid,
  output evcmd_t            cmd,
  output logic              done
);
  pstate_e             st;
  logic [WORD_W-1:0]   word;
  logic [2:0]          bi;
  logic                have, pend;
  logic [7:0]          len, idx;
  logic [CHAN_W-1:0]   acc_chan;
  logic [TS_W-1:0]     acc_ts;
  logic [EADDR_W-1:0]  acc_addr;
  logic [EDATA_W-1:0]  acc_data;
  logic [7:0]          cur;
  logic                take, rec_begin;

  assign cur       = word[WORD_W-1 -: 8];
  assign take      = have && (st == PS_LEN || st == PS_BODY);
  assign rec_begin = take && (st == PS_LEN);
  assign buf_rd    = (st == PS_LEN || st == PS_BODY) && !have && !pend && !buf_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PS_IDLE;
      word      <= '0;
      bi        <= '0;
      have      <= 1'b0;
      pend      <= 1'b0;
      len       <= '0;
      idx       <= '0;
      acc_chan  <= '0;
      acc_ts    <= '0;
      acc_addr  <= '0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
      done      <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      pend      <= buf_rd;
      if (pend) begin
        word <= buf_data;
        have <= 1'b1;
        bi   <= '0;
      end
      if (take) begin
        word <= word << 8;
        bi   <= bi + 3'd1;
        if (bi == 3'd7) have <= 1'b0;
      end
      unique case (st)
        PS_IDLE: if (start) begin
          st   <= PS_LEN;
          have <= 1'b0;
        end
        PS_LEN: if (take) begin
          acc_chan <= '0;
          acc_ts   <= '0;
          acc_addr <= '0;
          if (cur == 8'd0) begin
            st   <= PS_IDLE;
            done <= 1'b1;
          end else if (cur == 8'd1) begin
            st <= PS_ISSUE;
          end else begin
            len <= cur;
            idx <= 8'd1;
            st  <= PS_BODY;
          end
        end
        PS_BODY: if (take) begin
          if (idx >= 8'd1 && idx <= 8'd3)
            acc_chan <= {cur, acc_chan[CHAN_W-1:8]};
          else if (idx >= 8'd4 && idx <= 8'd11)
            acc_ts <= {cur, acc_ts[TS_W-1:8]};
          else if (idx == 8'd12)
            acc_addr <= cur;
          if (idx == len - 8'd1) st <= PS_ISSUE;
          else idx <= idx + 8'd1;
        end
        PS_ISSUE: if (!dn_busy) begin
          cmd.chan  <= acc_chan;
          cmd.ts    <= acc_ts;
          cmd.addr  <= acc_addr;
          cmd.data  <= acc_data;
          cmd_valid <= 1'b1;
          st        <= PS_LEN;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  // one byte lane per data position, cleared at each record start
  for (genvar k = 0; k < MAX_DBYTES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || rec_begin)
        acc_data[8*k +: 8] <= '0;
      else if (take && st == PS_BODY && idx == 8'(HDR_BYTES + k))
        acc_data[8*k +: 8] <= cur;
    end
  end
endmodule

// File: rtl/evrec_dma.sv
module evrec_dma
  import evrec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BURST = 4,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_base_wr,
  input  logic [AW-1:0]      ctl_base_data,
  input  logic               ctl_start,
  input  logic [1:0]         ctl_err_clr,
  output logic               stat_enable,
  output logic [1:0]         stat_err,
  output logic               m_ar_valid,
  input  logic               m_ar_ready,
  output logic [AW-1:0]      m_ar_addr,
  output logic [7:0]         m_ar_len,
  output logic [2:0]         m_ar_size,
  output logic [1:0]         m_ar_burst,
  input  logic               m_r_valid,
  output logic               m_r_ready,
  input  logic [WORD_W-1:0]  m_r_data,
  output logic               ev_valid,
  output logic [CHAN_W-1:0]  ev_chan,
  output logic [TS_W-1:0]    ev_time,
  output logic [EADDR_W-1:0] ev_addr,
  output logic [EDATA_W-1:0] ev_data,
  input  logic               ev_busy,
  input  logic               ev_err_underflow,
  input  logic               ev_err_unreach
);
  logic [AW-1:0]     base_q;
  logic              active, start, done;
  logic              push, buf_rd, buf_empty;
  logic [WORD_W-1:0] push_data, buf_data;
  logic [CW-1:0]     buf_count;
  evcmd_t            cmd;

  assign start       = ctl_start && !active;
  assign stat_enable = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      stat_err <= '0;
    end else begin
      if (ctl_base_wr && !active) base_q <= ctl_base_data;
      stat_err <= (stat_err & ~ctl_err_clr) | {ev_err_unreach, ev_err_underflow};
    end
  end

  evrec_fetch #(.AW(AW), .BURST(BURST), .DEPTH(DEPTH), .CW(CW)) u_fetch (
    .clk, .rst, .start, .base(base_q), .stop(done), .buf_count, .active,
    .ar_valid(m_ar_valid), .ar_ready(m_ar_ready), .ar_addr(m_ar_addr),
    .ar_len(m_ar_len), .ar_size(m_ar_size), .ar_burst(m_ar_burst),
    .r_valid(m_r_valid), .r_ready(m_r_ready), .r_data(m_r_data),
    .push, .push_data
  );

  evrec_wordbuf #(.W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk, .rst, .clr(done), .wr_en(push), .wr_data(push_data),
    .rd_en(buf_rd), .rd_data(buf_data), .empty(buf_empty), .count(buf_count)
  );

  evrec_parser u_parse (
    .clk, .rst, .start, .buf_empty, .buf_rd, .buf_data,
    .dn_busy(ev_busy), .cmd_valid(ev_valid), .cmd, .done
  );

  assign ev_chan = cmd.chan;
  assign ev_time = cmd.ts;
  assign ev_addr = cmd.addr;
  assign ev_data = cmd.data;
endmodule

// File: rtl/evrec_dma_chk.sv
module evrec_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ar_valid,
  input logic          ar_ready,
  input logic [AW-1:0] ar_addr,
  input logic          stat_enable,
  input logic          ev_valid,
  input logic          ev_busy,
  input logic [1:0]    stat_err,
  input logic [1:0]    err_clr,
  input logic          err_uf,
  input logic          err_ur
);
  // R2
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));
  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_enable |-> !ar_valid);
  // R1
  cmd_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> stat_enable);
  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> !ev_valid);
  // R6
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> !$past(ev_busy));
  // R8
  uf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_err[0]) |-> $past(err_uf));
  // R8
  ur_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_err[1]) |-> $past(err_ur));
  // R8
  uf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat_err[0] && !err_clr[0] |=> stat_err[0]);
  // R8
  ur_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat_err[1] && !err_clr[1] |=> stat_err[1]);
endmodule

bind evrec_dma evrec_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ar_valid(m_ar_valid), .ar_ready(m_ar_ready),
  .ar_addr(m_ar_addr), .stat_enable(stat_enable), .ev_valid(ev_valid),
  .ev_busy(ev_busy), .stat_err(stat_err), .err_clr(ctl_err_clr),
  .err_uf(ev_err_underflow), .err_ur(ev_err_unreach)
);

// File: tb/evrec_dma_tb.sv
`timescale 1ns/1ps
module evrec_dma_tb;
  localparam int AW = 32;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          ctl_base_wr = 0, ctl_start = 0;
  logic [AW-1:0] ctl_base_data = '0;
  logic [1:0]    ctl_err_clr = '0;
  logic          stat_enable;
  logic [1:0]    stat_err;
  logic          m_ar_valid, m_r_valid, m_r_ready;
  logic          m_ar_ready = 1'b1;
  logic [AW-1:0] m_ar_addr;
  logic [7:0]    m_ar_len;
  logic [2:0]    m_ar_size;
  logic [1:0]    m_ar_burst;
  logic [63:0]   m_r_data;
  logic          ev_valid, ev_busy;
  logic [23:0]   ev_chan;
  logic [63:0]   ev_time;
  logic [7:0]    ev_addr;
  logic [511:0]  ev_data;
  logic          ev_err_underflow = 0, ev_err_unreach = 0;

  evrec_dma #(.AW(AW), .BURST(BURST), .DEPTH(16)) u_dut (.*);

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory image
  logic [7:0]  img [1024];
  logic [63:0] mem [128];
  task automatic pack_img();
    for (int w = 0; w < 128; w++)
      for (int j = 0; j < 8; j++) mem[w][(7-j)*8 +: 8] = img[8*w+j];
  endtask

  // expected commands
  logic [23:0]  exp_ch [16];
  logic [63:0]  exp_ts [16];
  logic [7:0]   exp_ad [16];
  logic [511:0] exp_dt [16];
  int exp_n;

  task automatic add_rec(inout int p, input logic [23:0] ch, input logic [63:0] ts,
                         input logic [7:0] ad, input logic [511:0] d, input int nb);
    logic [511:0] m;
    m = '0;
    img[p] = 8'(13 + nb); p++;
    for (int i = 0; i < 3; i++) begin img[p] = ch[8*i +: 8]; p++; end
    for (int i = 0; i < 8; i++) begin img[p] = ts[8*i +: 8]; p++; end
    img[p] = ad; p++;
    for (int i = 0; i < nb; i++) begin img[p] = d[8*i +: 8]; m[8*i +: 8] = d[8*i +: 8]; p++; end
    exp_ch[exp_n] = ch; exp_ts[exp_n] = ts; exp_ad[exp_n] = ad; exp_dt[exp_n] = m;
    exp_n++;
  endtask

  // read slave model
  logic [AW-1:0] q_addr [8];
  int q_head = 0, q_tail = 0, q_cnt = 0, beat = 0;
  logic [AW-1:0] ar_exp;
  int ar_bad = 0, ar_cnt = 0;
  assign m_r_valid = (q_cnt != 0);
  assign m_r_data  = mem[7'((q_addr[q_head[2:0]] >> 3) + AW'(beat))];

  initial forever begin
    @(posedge clk);
    if (rst) begin
      q_head <= 0; q_tail <= 0; q_cnt <= 0; beat <= 0;
    end else begin
      if (m_ar_valid && m_ar_ready) begin
        q_addr[q_tail[2:0]] <= m_ar_addr;
        q_tail <= q_tail + 1;
        ar_cnt++;
        if (m_ar_addr != ar_exp || m_ar_len != 8'(BURST-1) ||
            m_ar_size != 3'b011 || m_ar_burst != 2'b01) ar_bad++;
        ar_exp = ar_exp + AW'(BURST*8);
      end
      if (m_r_valid && m_r_ready) begin
        if (beat == BURST-1) begin beat <= 0; q_head <= q_head + 1; end
        else beat <= beat + 1;
      end
      q_cnt <= q_cnt + ((m_ar_valid && m_ar_ready) ? 1 : 0)
                     - ((m_r_valid && m_r_ready && beat == BURST-1) ? 1 : 0);
    end
  end

  // downstream model and command log
  int busy_hold = 0, busy_cnt = 0;
  logic busy_d = 1'b0;
  assign ev_busy = (busy_cnt != 0);
  logic [23:0]  rx_ch [16];
  logic [63:0]  rx_ts [16];
  logic [7:0]   rx_ad [16];
  logic [511:0] rx_dt [16];
  int rx_t [16];
  int rx_n = 0, bz_viol = 0;

  initial forever begin
    @(posedge clk);
    busy_d <= ev_busy;
    if (rst) busy_cnt <= 0;
    else if (ev_valid) begin
      if (busy_d) bz_viol++;
      if (rx_n < 16) begin
        rx_ch[rx_n] = ev_chan; rx_ts[rx_n] = ev_time;
        rx_ad[rx_n] = ev_addr; rx_dt[rx_n] = ev_data; rx_t[rx_n] = cyc;
      end
      rx_n++;
      busy_cnt <= busy_hold;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic t_reset();
    @(negedge clk);
    chk(stat_enable == 0, "R9", "enable", 512'(stat_enable), 0);
    chk(ev_valid == 0, "R9", "ev_valid", 512'(ev_valid), 0);
    chk(m_ar_valid == 0, "R9", "ar_valid", 512'(m_ar_valid), 0);
    chk(stat_err == 0, "R9", "err", 512'(stat_err), 0);
  endtask

  task automatic run_xfer(input logic [AW-1:0] base, input int hold, input bit restart);
    int wait_c;
    rx_n = 0; bz_viol = 0; ar_bad = 0; ar_cnt = 0; ar_exp = base; busy_hold = hold;
    @(negedge clk); ctl_base_wr = 1; ctl_base_data = base;
    @(negedge clk); ctl_base_wr = 0; ctl_start = 1;
    @(negedge clk); ctl_start = 0;
    chk(stat_enable == 1, "R1", "enable after start", 512'(stat_enable), 1);
    if (restart) begin
      // R1: restart during a run must be ignored
      @(negedge clk); ctl_base_wr = 1; ctl_base_data = 32'h3F8;
      @(negedge clk); ctl_base_wr = 0; ctl_start = 1;
      @(negedge clk); ctl_start = 0;
    end
    wait_c = 0;
    while (stat_enable && wait_c < 20000) begin @(negedge clk); wait_c++; end
    chk(!stat_enable, "R1", "enable cleared", 512'(stat_enable), 0);
    chk(rx_n == exp_n, "R5", "command count", 512'(rx_n), 512'(exp_n));
    for (int i = 0; i < exp_n && i < rx_n; i++) begin
      chk(rx_ch[i] == exp_ch[i], "R4", "channel", 512'(rx_ch[i]), 512'(exp_ch[i]));
      chk(rx_ts[i] == exp_ts[i], "R3 R4", "timestamp", 512'(rx_ts[i]), 512'(exp_ts[i]));
      chk(rx_ad[i] == exp_ad[i], "R4", "sub-address", 512'(rx_ad[i]), 512'(exp_ad[i]));
      chk(rx_dt[i] == exp_dt[i], "R4", "data", rx_dt[i], exp_dt[i]);
      if (i > 0)
        chk(rx_t[i] - rx_t[i-1] >= hold + 2, "R6", "command spacing",
            512'(rx_t[i] - rx_t[i-1]), 512'(hold + 2));
    end
    chk(bz_viol == 0, "R6", "issue while busy", 512'(bz_viol), 0);
    chk(ar_bad == 0 && ar_cnt > 0, "R2", "burst requests bad", 512'(ar_bad), 0);
    repeat (60) @(negedge clk);
    chk(rx_n == exp_n, "R7", "no command after terminator", 512'(rx_n), 512'(exp_n));
    chk(stat_err == 0, "R8", "no spurious error", 512'(stat_err), 0);
  endtask

  task automatic t_errors();
    @(negedge clk); ev_err_underflow = 1;
    @(negedge clk); ev_err_underflow = 0;
    chk(stat_err == 2'b01, "R8", "underflow latched", 512'(stat_err), 1);
    repeat (5) @(negedge clk);
    chk(stat_err == 2'b01, "R8", "underflow held", 512'(stat_err), 1);
    ev_err_unreach = 1;
    @(negedge clk); ev_err_unreach = 0;
    chk(stat_err == 2'b11, "R8", "unreachable latched", 512'(stat_err), 3);
    ctl_err_clr = 2'b01;
    @(negedge clk); ctl_err_clr = 2'b00;
    chk(stat_err == 2'b10, "R8", "clear bit0", 512'(stat_err), 2);
    ctl_err_clr = 2'b10; ev_err_unreach = 1;
    @(negedge clk); ctl_err_clr = 2'b00; ev_err_unreach = 0;
    chk(stat_err == 2'b10, "R8", "set beats clear", 512'(stat_err), 2);
    ctl_err_clr = 2'b10;
    @(negedge clk); ctl_err_clr = 2'b00;
    chk(stat_err == 2'b00, "R8", "clear bit1", 512'(stat_err), 0);
  endtask

  initial begin
    int p;
    for (int i = 0; i < 1024; i++) img[i] = 8'((i * 37 + 11) | 1);
    // list A at 0
    exp_n = 0; p = 0;
    add_rec(p, 24'h000001, 64'h23, 8'h12, 512'h33, 1);
    add_rec(p, 24'h000901, 64'h902, 8'h11,
            512'(160'h0123456789ABCDEF0123456789ABCDEFFEDCBA98), 20);
    add_rec(p, 24'h000081, 64'h288, 8'h88, 512'h8888, 2);
    img[p] = 8'h00;
    pack_img();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    run_xfer(32'h0, 3, 1'b1);
    // list B at 512, run straight after
    exp_n = 0; p = 512;
    for (int i = 0; i < 5; i++)
      add_rec(p, 24'h10 + 24'(i), 64'h10000 + 64'(i), 8'h20 + 8'(i*16),
              {64{8'h77}} ^ 512'(i * 8'h11), i + 1);
    add_rec(p, 24'hABCDEF, 64'hFEDCBA9876543210, 8'h5A,
            {8{64'h0123456789ABCDEF}}, 64);
    img[p] = 8'h00;
    pack_img();
    run_xfer(32'h200, 40, 1'b0);
    t_errors();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule